// File: doc/BRIEF.md
# TDM Audio Serial Port

This block moves eight channels of 32-bit audio over a single time-division-multiplexed serial link. The bit clock comes from outside. The block oversamples that clock with its own system clock, sends a registered copy of it back out, and derives all frame timing from the clock's edges. A slot/bit counter walks through the 256 bit positions of each frame. The block drives a one-bit-wide frame marker during the first bit of slot 0, launches transmit bits after each falling edge and captures receive bits on each rising edge.

Software-side logic writes transmit words into a per-slot holding store. Each write gives a slot index. At the first bit of each slot, the stored word for that slot is moved into the shifter and the entry is marked empty. If nothing was written for the slot, zeros go out. Each received word appears on a parallel output together with its slot number and a one-cycle valid strobe.

Two inputs invert the bit clock and the frame marker, so that links with the other polarities can be served. They are intended to be changed only while reset is held.

Top module: `tdm_port`

## Requirements
- R1: `bclk_out` equals the value `bclk_in` had one system clock earlier.
- R2: A frame is 8 slots of 32 bits. The active frame marker lasts exactly one bit period, coinciding with bit 0 of slot 0, and recurs every 256 bit periods.
- R3: With `inv_fs` = 1, `fs_out` is low during the marker bit and high at all other times. With `inv_fs` = 0, it is high only during the marker bit.
- R4: Transmit words are sent most significant bit first. `tx_sd` changes only after a falling bit-clock edge, so it is stable at the following rising edge.
- R5: At bit 0 of each slot, the holding entry for that slot is loaded into the shifter and then marked empty. An empty entry sends 32 zeros.
- R6: Suppose a write to a slot lands in the same system cycle as that slot's load. Then the load uses the entry's previous content and state, and the new word stays pending for the same slot in the next frame.
- R7: Receive bits are captured on rising bit-clock edges, most significant bit first. After bit 31 of a slot is captured, `rx_word` shows the word and `rx_slot` shows its slot index (0 to 7). At the same time, `rx_valid` pulses high for exactly one system cycle.
- R8: With `inv_bclk` = 1, the roles of the two bit-clock edges swap, for both launch and capture.
- R9: During reset, `fs_out` equals `inv_fs` and `tx_sd` and `rx_valid` are 0. The counter starts so that the first qualified falling edge begins slot 0, bit 0. Edges in the first four cycles after reset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| inv_bclk | input | 1 | Swap the launch and capture edges of the bit clock |
| inv_fs | input | 1 | Make the frame marker active low |
| bclk_in | input | 1 | External serial bit clock |
| bclk_out | output | 1 | Registered copy of the bit clock |
| fs_out | output | 1 | Frame marker |
| tx_sd | output | 1 | Serial transmit data |
| rx_sd | input | 1 | Serial receive data |
| tx_wr | input | 1 | Write strobe for the transmit holding store |
| tx_slot | input | 3 | Slot index of the word being written |
| tx_word | input | 32 | Transmit word to hold |
| rx_valid | output | 1 | One-cycle strobe for a completed receive word |
| rx_slot | output | 3 | Slot index of the received word |
| rx_word | output | 32 | Received word |

## Verification
Two events can land in the same system cycle: a holding-store write to a slot, and the slot-start load that reads and empties that same entry. The bench writes slot 5 exactly in the cycle its load takes effect. It also leaves slot 3 unwritten. The behavioural model expects zeros in slot 5 of the first frame and, in each later frame, the word written during the previous frame's collision. Each transmitted bit is compared at the receiver's sampling edge.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  localparam int unsigned DEF_SLOTS  = 8;
  localparam int unsigned DEF_WORD_W = 32;
  localparam int unsigned DEF_SYNC   = 2;
  // quiet cycles after reset before edges are trusted
  localparam int unsigned ARM_CYCLES = 4;
endpackage

// File: rtl/tdm_edge.sv
module tdm_edge #(
  parameter int SYNC  = tdm_pkg::DEF_SYNC,
  parameter int ARM_N = tdm_pkg::ARM_CYCLES,
  localparam int ARM_W = $clog2(ARM_N + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic inv,
  input  logic clk_raw,
  input  logic dat_raw,
  output logic rise,
  output logic fall,
  output logic dat_s
);
  logic [SYNC-1:0]  csync, dsync;
  logic             lvl, lvl_q;
  logic [ARM_W-1:0] arm;
  logic             armed;

  assign lvl   = csync[SYNC-1] ^ inv;
  assign armed = (arm == ARM_W'(ARM_N));
  assign rise  = armed & lvl & ~lvl_q;
  assign fall  = armed & ~lvl & lvl_q;
  assign dat_s = dsync[SYNC-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      csync <= '0;
      dsync <= '0;
      lvl_q <= 1'b0;
      arm   <= '0;
    end else begin
      csync <= {csync[SYNC-2:0], clk_raw};
      dsync <= {dsync[SYNC-2:0], dat_raw};
      lvl_q <= lvl;
      if (!armed) arm <= arm + 1'b1;
    end
  end
endmodule

// File: rtl/tdm_counter.sv
module tdm_counter #(
  parameter int SLOTS  = tdm_pkg::DEF_SLOTS,
  parameter int WORD_W = tdm_pkg::DEF_WORD_W,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int BIT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [SLOT_W-1:0] slot,
  output logic [BIT_W-1:0]  bitn,
  output logic [SLOT_W-1:0] nxt_slot,
  output logic [BIT_W-1:0]  nxt_bit,
  output logic              run
);
  logic last_bit;

  always_comb begin
    last_bit = (bitn == BIT_W'(WORD_W - 1));
    nxt_bit  = last_bit ? '0 : bitn + 1'b1;
    if (!last_bit)                         nxt_slot = slot;
    else if (slot == SLOT_W'(SLOTS - 1))   nxt_slot = '0;
    else                                   nxt_slot = slot + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= SLOT_W'(SLOTS - 1);
      bitn <= BIT_W'(WORD_W - 1);
      run  <= 1'b0;
    end else if (adv) begin
      slot <= nxt_slot;
      bitn <= nxt_bit;
      run  <= 1'b1;
    end
  end

  // R2
  slot_step_chk: assert property (@(posedge clk) disable iff (rst)
    (slot != $past(slot)) |-> (bitn == '0));
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx #(
  parameter int SLOTS  = tdm_pkg::DEF_SLOTS,
  parameter int WORD_W = tdm_pkg::DEF_WORD_W,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int BIT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall,
  input  logic              inv_fs,
  input  logic [SLOT_W-1:0] nxt_slot,
  input  logic [BIT_W-1:0]  nxt_bit,
  input  logic              wr,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [WORD_W-1:0] wr_word,
  output logic              tx_sd,
  output logic              fs_out
);
  logic [WORD_W-1:0] hold [SLOTS];
  logic [SLOTS-1:0]  vld;
  logic [WORD_W-1:0] sh, load_word;
  logic              load;

  assign load = fall && (nxt_bit == '0);

  always_comb begin
    load_word = vld[nxt_slot] ? hold[nxt_slot] : '0;
  end

  always_ff @(posedge clk) begin
    if (wr) hold[wr_slot] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else begin
      if (load) vld[nxt_slot] <= 1'b0;
      if (wr)   vld[wr_slot]  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      tx_sd  <= 1'b0;
      fs_out <= inv_fs;
    end else if (fall) begin
      if (load) begin
        tx_sd <= load_word[WORD_W-1];
        sh    <= {load_word[WORD_W-2:0], 1'b0};
      end else begin
        tx_sd <= sh[WORD_W-1];
        sh    <= {sh[WORD_W-2:0], 1'b0};
      end
      fs_out <= ((nxt_slot == '0) && (nxt_bit == '0)) ^ inv_fs;
    end
  end

  // R5
  empty_load_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !vld[nxt_slot]) |=> (tx_sd == 1'b0));
endmodule

// File: rtl/tdm_rx.sv
module tdm_rx #(
  parameter int SLOTS  = tdm_pkg::DEF_SLOTS,
  parameter int WORD_W = tdm_pkg::DEF_WORD_W,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int BIT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise,
  input  logic              run,
  input  logic              sd,
  input  logic [SLOT_W-1:0] slot,
  input  logic [BIT_W-1:0]  bitn,
  output logic [WORD_W-1:0] rx_word,
  output logic [SLOT_W-1:0] rx_slot,
  output logic              rx_valid
);
  logic [WORD_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh       <= '0;
      rx_word  <= '0;
      rx_slot  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (rise && run) begin
        sh <= {sh[WORD_W-2:0], sd};
        if (bitn == BIT_W'(WORD_W - 1)) begin
          rx_word  <= {sh[WORD_W-2:0], sd};
          rx_slot  <= slot;
          rx_valid <= 1'b1;
        end
      end
    end
  end

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
endmodule

// File: rtl/tdm_port.sv
module tdm_port #(
  parameter int SLOTS  = tdm_pkg::DEF_SLOTS,
  parameter int WORD_W = tdm_pkg::DEF_WORD_W,
  parameter int SYNC   = tdm_pkg::DEF_SYNC,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int BIT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inv_bclk,
  input  logic              inv_fs,
  input  logic              bclk_in,
  output logic              bclk_out,
  output logic              fs_out,
  output logic              tx_sd,
  input  logic              rx_sd,
  input  logic              tx_wr,
  input  logic [SLOT_W-1:0] tx_slot,
  input  logic [WORD_W-1:0] tx_word,
  output logic              rx_valid,
  output logic [SLOT_W-1:0] rx_slot,
  output logic [WORD_W-1:0] rx_word
);
  logic              rise, fall, rx_s, run;
  logic [SLOT_W-1:0] slot, nxt_slot;
  logic [BIT_W-1:0]  bitn, nxt_bit;

  always_ff @(posedge clk) bclk_out <= bclk_in;

  tdm_edge #(.SYNC(SYNC)) u_edge (
    .clk(clk), .rst(rst), .inv(inv_bclk), .clk_raw(bclk_in), .dat_raw(rx_sd),
    .rise(rise), .fall(fall), .dat_s(rx_s)
  );

  tdm_counter #(.SLOTS(SLOTS), .WORD_W(WORD_W)) u_cnt (
    .clk(clk), .rst(rst), .adv(fall), .slot(slot), .bitn(bitn),
    .nxt_slot(nxt_slot), .nxt_bit(nxt_bit), .run(run)
  );

  tdm_tx #(.SLOTS(SLOTS), .WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst(rst), .fall(fall), .inv_fs(inv_fs),
    .nxt_slot(nxt_slot), .nxt_bit(nxt_bit),
    .wr(tx_wr), .wr_slot(tx_slot), .wr_word(tx_word),
    .tx_sd(tx_sd), .fs_out(fs_out)
  );

  tdm_rx #(.SLOTS(SLOTS), .WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst(rst), .rise(rise), .run(run), .sd(rx_s),
    .slot(slot), .bitn(bitn),
    .rx_word(rx_word), .rx_slot(rx_slot), .rx_valid(rx_valid)
  );

  // R1
  bclk_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    bclk_out == $past(bclk_in));

  // R2
  fs_position_chk: assert property (@(posedge clk) disable iff (rst)
    (fs_out != inv_fs) |-> ((slot == '0) && (bitn == '0)));
endmodule

// File: tb/sim_tdm_port.sv
module sim_tdm_port;
  logic        clk = 1'b0, rst = 1'b1;
  logic        inv_b = 1'b0, inv_f = 1'b0;
  logic        bclk_in = 1'b0, rx_sd = 1'b0, tx_wr = 1'b0;
  logic [2:0]  tx_slot = '0;
  logic [31:0] tx_word = '0;
  logic        bclk_out, fs_out, tx_sd, rx_valid;
  logic [2:0]  rx_slot;
  logic [31:0] rx_word;

  always #10 clk = ~clk;

  tdm_port u0 (
    .clk(clk), .rst(rst), .inv_bclk(inv_b), .inv_fs(inv_f),
    .bclk_in(bclk_in), .bclk_out(bclk_out), .fs_out(fs_out), .tx_sd(tx_sd),
    .rx_sd(rx_sd), .tx_wr(tx_wr), .tx_slot(tx_slot), .tx_word(tx_word),
    .rx_valid(rx_valid), .rx_slot(rx_slot), .rx_word(rx_word)
  );

  int vectors = 0, miscompares = 0;
  int ph, mpos, mode, frame_id;
  bit started, exp_pend;
  logic [31:0] hold [8];
  bit          vld [8];
  logic [31:0] cur_tx, rxsh, exp_word, lfsr;
  int          exp_slot;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h pos=%0d", tag, act, exp, mpos);
    end
  endtask

  function automatic logic [31:0] mkword(int s);
    return 32'hC0DE_0000 ^ (32'(s) << 24) ^ (32'(frame_id) << 4) ^ 32'(s);
  endfunction

  task automatic do_reset(bit ib, bit ifs, int md);
    @(negedge clk);
    rst = 1'b1; tx_wr = 1'b0;
    inv_b = ib; inv_f = ifs; mode = md;
    ph = 6;
    bclk_in = 1'b1 ^ ib;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", 32'(fs_out), 32'(ifs));
    chk("R9", 32'(tx_sd), 32'd0);
    chk("R9", 32'(rx_valid), 32'd0);
    mpos = 255; started = 0; exp_pend = 0; rxsh = '0; cur_tx = '0;
    for (int i = 0; i < 8; i++) vld[i] = 0;
    rst = 1'b0;
  endtask

  task automatic run_cycles(int n);
    repeat (n) begin
      @(negedge clk);
      // checks against state after the last edge
      chk("R1", 32'(bclk_out), 32'(bclk_in));
      if (ph == 8 && exp_pend) begin
        chk(inv_b ? "R8" : "R7", 32'(rx_valid), 32'd1);
        chk("R7", rx_word, exp_word);
        chk("R7", 32'(rx_slot), 32'(exp_slot));
        exp_pend = 0;
      end else begin
        chk("R7", 32'(rx_valid), 32'd0);
      end
      if (ph == 6 && started) begin
        chk(inv_f ? "R3" : "R2", 32'(fs_out), 32'((mpos == 0) ^ inv_f));
        if (mode == 1 && mpos / 32 == 5)
          chk("R6", 32'(tx_sd), 32'(cur_tx[31 - mpos % 32]));
        else if (cur_tx == 0)
          chk("R5", 32'(tx_sd), 32'd0);
        else
          chk(inv_b ? "R8" : "R4", 32'(tx_sd), 32'(cur_tx[31 - mpos % 32]));
      end
      // drive
      tx_wr = 1'b0;
      ph = (ph + 1) % 12;
      bclk_in = (ph >= 6) ^ inv_b;
      if (ph == 2) begin
        mpos = (mpos + 1) % 256;
        started = 1;
        if (mpos == 0) frame_id++;
        if (mpos % 32 == 0) begin
          int s = mpos / 32;
          cur_tx = vld[s] ? hold[s] : 32'd0;
          vld[s] = 0;
          if (mode == 1 && s == 5) begin
            tx_word = mkword(5); tx_slot = 3'd5; tx_wr = 1'b1;
            hold[5] = tx_word; vld[5] = 1;
          end
        end
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        rx_sd = lfsr[0];
      end
      if (ph == 8 && started) begin
        rxsh = {rxsh[30:0], rx_sd};
        if (mpos % 32 == 31) begin
          exp_word = rxsh; exp_slot = mpos / 32; exp_pend = 1;
        end
      end
      if (ph == 4 && started && mpos % 32 == 5) begin
        int ts = (mpos / 32 + 1) % 8;
        if (!(mode == 1 && (ts == 3 || ts == 5))) begin
          tx_word = mkword(ts); tx_slot = 3'(ts); tx_wr = 1'b1;
          hold[ts] = tx_word; vld[ts] = 1;
        end
      end
    end
  endtask

  initial begin
    frame_id = 0; lfsr = 32'h2545_F491; ph = 6; mpos = 255; mode = 0;
    do_reset(1'b0, 1'b0, 0);
    run_cycles(3 * 3072 + 40);
    do_reset(1'b0, 1'b0, 1);
    run_cycles(3 * 3072 + 40);
    do_reset(1'b1, 1'b1, 1);
    run_cycles(3 * 3072 + 40);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule